// File: doc/BRIEF.md
# Key-Locked Opcode-to-ALU Decoder

This block translates the 4-bit operation field of an instruction into the 4-bit operation code that drives an accumulator ALU. It is an obfuscated decoder. Before the lookup, the opcode is mixed with four bits taken from a 16-bit unlock key. Every label of the lookup is stored already mixed with the correct value of those four bits. A netlist reader therefore sees a table that does not reveal the real instruction-to-operation assignment. The decoder reproduces the intended assignment only when the correct key is applied.

The block is purely combinational. The key is held elsewhere, and only one nibble of it, selected by a parameter, reaches the decoder. The other key bits belong to other locked logic and do not change this decoder's output. With a wrong nibble, the decoder still gives a defined code for every opcode, but the assignment is permuted: opcode `op` decodes as if it were opcode `op ^ key_nibble ^ correct_nibble`.

Top module: `lkd_opdec`

## Requirements
- R1: With key 16'hBFF9, opcodes decode to these ALU codes (opcode→code): 0→13 (load operand), 1→0 (pass accumulator), 2→1 (add), 3→2 (subtract), 4→3 (and), 5→4 (or), 6→5 (xor), 7→6 (shift left), 8→7 (shift right), 9→8 (rotate left), 10→9 (rotate right), 11→10 (increment), 12→11 (decrement), 13→12 (invert), 14→14 (clear).
- R2: An opcode that matches no stored label after mixing gives ALU code 0 (pass accumulator). With key 16'hBFF9 this is opcode 15.
- R3: For key bits [3:0] equal to k, opcode `op` gives the R1/R2 code of opcode `op ^ k ^ 4'h9`.
- R4: Flipping any single one of key bits [3:0] away from the correct value makes at least one of the 16 opcodes decode differently from R1/R2.
- R5: Key bits [15:4] have no effect on the output.
- R6: The output is combinational, is a defined value for every known input pair, and follows an input change with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 4 | Instruction operation field |
| key_i | input | 16 | Full unlock key; the decoder uses bits [3:0] |
| alu_op_o | output | 4 | Decoded ALU operation code |

## Verification
The hardest cases to reach are the wrong-key cases. The decoder's behaviour there is a permutation that never shows up with the correct key, and no single wrong key covers every mixing pattern. The stimulus sweeps all sixteen values of the used key nibble against all sixteen opcodes, and predicts each result from the XOR-permutation rule. It then flips each of the sixteen key bits on its own around the correct key. For the four used bits it requires at least one observed difference from the intended mapping. For the twelve unused bits it requires exact agreement on every opcode.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  localparam int OPC_W = 4;
  localparam int ALU_W = 4;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] LOCK_KEY_DEFAULT = 16'hBFF9;

  typedef enum logic [ALU_W-1:0] {
    ALU_PASS_ACC = 4'd0,
    ALU_ADD      = 4'd1,
    ALU_SUB      = 4'd2,
    ALU_AND      = 4'd3,
    ALU_OR       = 4'd4,
    ALU_XOR      = 4'd5,
    ALU_SHL      = 4'd6,
    ALU_SHR      = 4'd7,
    ALU_ROL      = 4'd8,
    ALU_ROR      = 4'd9,
    ALU_INC      = 4'd10,
    ALU_DEC      = 4'd11,
    ALU_NOT      = 4'd12,
    ALU_LOAD     = 4'd13,
    ALU_CLEAR    = 4'd14
  } alu_op_e;

  // Plain instruction opcodes (before locking)
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_AND   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_OR    = 4'd5;
  localparam logic [OPC_W-1:0] OPC_XOR   = 4'd6;
  localparam logic [OPC_W-1:0] OPC_SHL   = 4'd7;
  localparam logic [OPC_W-1:0] OPC_SHR   = 4'd8;
  localparam logic [OPC_W-1:0] OPC_ROL   = 4'd9;
  localparam logic [OPC_W-1:0] OPC_ROR   = 4'd10;
  localparam logic [OPC_W-1:0] OPC_INC   = 4'd11;
  localparam logic [OPC_W-1:0] OPC_DEC   = 4'd12;
  localparam logic [OPC_W-1:0] OPC_NOT   = 4'd13;
  localparam logic [OPC_W-1:0] OPC_CLEAR = 4'd14;

endpackage

// File: rtl/lkd_key_tap.sv
module lkd_key_tap #(
  parameter int KEY_W   = 16,
  parameter int TAP_LSB = 0,
  parameter int TAP_W   = 4
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [TAP_W-1:0] tap_o
);

  // Bits outside the tap feed other locked logic; fold them so they are consumed.
  logic unused_key_fold;
  assign unused_key_fold = ^key_i;

  assign tap_o = key_i[TAP_LSB +: TAP_W];

endmodule

// File: rtl/lkd_sel_mix.sv
module lkd_sel_mix #(
  parameter int W = 4
) (
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] sel_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign sel_o[b] = sel_i[b] ^ mask_i[b];
  end

endmodule

// File: rtl/lkd_case_table.sv
module lkd_case_table
  import lkd_pkg::*;
#(
  parameter logic [OPC_W-1:0] LABEL_KEY = 4'h9
) (
  input  logic [OPC_W-1:0] mixed_i,
  output logic [ALU_W-1:0] alu_o
);

  alu_op_e op_n;

  // Every label is stored pre-mixed with the correct key nibble.
  always_comb begin
    op_n = ALU_PASS_ACC;
    case (mixed_i)
      OPC_LOAD  ^ LABEL_KEY: op_n = ALU_LOAD;
      OPC_STORE ^ LABEL_KEY: op_n = ALU_PASS_ACC;
      OPC_ADD   ^ LABEL_KEY: op_n = ALU_ADD;
      OPC_SUB   ^ LABEL_KEY: op_n = ALU_SUB;
      OPC_AND   ^ LABEL_KEY: op_n = ALU_AND;
      OPC_OR    ^ LABEL_KEY: op_n = ALU_OR;
      OPC_XOR   ^ LABEL_KEY: op_n = ALU_XOR;
      OPC_SHL   ^ LABEL_KEY: op_n = ALU_SHL;
      OPC_SHR   ^ LABEL_KEY: op_n = ALU_SHR;
      OPC_ROL   ^ LABEL_KEY: op_n = ALU_ROL;
      OPC_ROR   ^ LABEL_KEY: op_n = ALU_ROR;
      OPC_INC   ^ LABEL_KEY: op_n = ALU_INC;
      OPC_DEC   ^ LABEL_KEY: op_n = ALU_DEC;
      OPC_NOT   ^ LABEL_KEY: op_n = ALU_NOT;
      OPC_CLEAR ^ LABEL_KEY: op_n = ALU_CLEAR;
      default:               op_n = ALU_PASS_ACC;
    endcase
  end

  assign alu_o = op_n;

endmodule

// File: rtl/lkd_opdec.sv
module lkd_opdec
  import lkd_pkg::*;
#(
  parameter int               TAP_LSB  = 0,
  parameter logic [KEY_W-1:0] LOCK_KEY = LOCK_KEY_DEFAULT
) (
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [ALU_W-1:0] alu_op_o
);

  localparam logic [OPC_W-1:0] LABEL_KEY = LOCK_KEY[TAP_LSB +: OPC_W];

  logic [OPC_W-1:0] key_nib;
  logic [OPC_W-1:0] sel_mixed;

  lkd_key_tap #(
    .KEY_W  (KEY_W),
    .TAP_LSB(TAP_LSB),
    .TAP_W  (OPC_W)
  ) u_tap (
    .key_i(key_i),
    .tap_o(key_nib)
  );

  lkd_sel_mix #(
    .W(OPC_W)
  ) u_mix (
    .sel_i (opcode_i),
    .mask_i(key_nib),
    .sel_o (sel_mixed)
  );

  lkd_case_table #(
    .LABEL_KEY(LABEL_KEY)
  ) u_table (
    .mixed_i(sel_mixed),
    .alu_o  (alu_op_o)
  );

endmodule

// File: rtl/lkd_opdec_chk.sv
module lkd_opdec_chk
  import lkd_pkg::*;
#(
  parameter int               TAP_LSB  = 0,
  parameter logic [KEY_W-1:0] LOCK_KEY = LOCK_KEY_DEFAULT
) (
  input logic [OPC_W-1:0] opcode_i,
  input logic [KEY_W-1:0] key_i,
  input logic [ALU_W-1:0] alu_op_o
);

  localparam logic [OPC_W-1:0] GOOD_NIB = LOCK_KEY[TAP_LSB +: OPC_W];

  logic [OPC_W-1:0] eff_opc;
  assign eff_opc = opcode_i ^ key_i[TAP_LSB +: OPC_W] ^ GOOD_NIB;

  always_comb begin
    if (!$isunknown({opcode_i, key_i}))
      AST_OUT_KNOWN: assert (!$isunknown(alu_op_o)); // R6
    if (key_i == LOCK_KEY && opcode_i == 4'd15)
      AST_UNMATCHED_PASS: assert (alu_op_o == 4'd0); // R2
    if (key_i == LOCK_KEY && opcode_i == 4'd0)
      AST_GOOD_KEY_LOAD: assert (alu_op_o == 4'd13); // R1
    if (key_i == LOCK_KEY && opcode_i == 4'd14)
      AST_GOOD_KEY_CLEAR: assert (alu_op_o == 4'd14); // R1
    if (eff_opc == 4'd15)
      AST_PERMUTED_DEFAULT: assert (alu_op_o == 4'd0); // R3
    if (eff_opc == 4'd2)
      AST_PERMUTED_ADD: assert (alu_op_o == 4'd1); // R3
  end

endmodule

bind lkd_opdec lkd_opdec_chk #(
  .TAP_LSB (TAP_LSB),
  .LOCK_KEY(LOCK_KEY)
) u_chk (
  .opcode_i(opcode_i),
  .key_i   (key_i),
  .alu_op_o(alu_op_o)
);

// File: tb/sim_lkd_opdec.sv
module sim_lkd_opdec;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] GOOD_KEY = 16'hBFF9;

  typedef struct {
    logic [3:0]  op;
    logic [15:0] key;
    logic [3:0]  exp;
    string       tag;
  } item_t;

  logic        clk;
  logic [3:0]  opcode;
  logic [15:0] key;
  logic [3:0]  alu_op;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    diff_seen = 0;
  bit    done = 0;

  lkd_opdec u0 (
    .opcode_i(opcode),
    .key_i   (key),
    .alu_op_o(alu_op)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Intended (unlocked) mapping, written from the requirements R1/R2
  function automatic logic [3:0] ref_map(input logic [3:0] op);
    case (op)
      4'd0:  return 4'd13;
      4'd1:  return 4'd0;
      4'd2:  return 4'd1;
      4'd3:  return 4'd2;
      4'd4:  return 4'd3;
      4'd5:  return 4'd4;
      4'd6:  return 4'd5;
      4'd7:  return 4'd6;
      4'd8:  return 4'd7;
      4'd9:  return 4'd8;
      4'd10: return 4'd9;
      4'd11: return 4'd10;
      4'd12: return 4'd11;
      4'd13: return 4'd12;
      4'd14: return 4'd14;
      default: return 4'd0;
    endcase
  endfunction

  // Locked behaviour model from R3
  function automatic logic [3:0] ref_locked(input logic [3:0] op, input logic [15:0] k);
    return ref_map(op ^ k[3:0] ^ 4'h9);
  endfunction

  task automatic drive(input logic [3:0] op, input logic [15:0] k,
                       input logic [3:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    opcode = op;
    key    = k;
    it.op = op; it.key = k; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic check_cond(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compares at the rising edge, half a period after the inputs moved
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (alu_op !== it.exp) begin
        n_fail++;
        $display("FAIL %s op=%0d key=%h actual=%0d expected=%0d",
                 it.tag, it.op, it.key, alu_op, it.exp);
      end
      if (alu_op !== ref_map(it.op)) diff_seen++;
    end
  end

  initial begin
    opcode = 4'd0;
    key    = 16'h0000;
    #(CLK_PERIOD + 1);
    // Initial state: key 0, opcode 0 -> ref_map(0^0^9)=ref_map(9)=8 (R3, R6)
    check_cond(alu_op === 4'd8, "R6 initial output", int'(alu_op), 8);

    // R1 and R2: correct key, all opcodes
    for (int op = 0; op < 16; op++)
      drive(4'(op), GOOD_KEY, ref_map(4'(op)), (op == 15) ? "R2 unmatched default" : "R1 good key map");
    drain();

    // R3: every nibble value against every opcode, upper bits random-ish
    for (int k = 0; k < 16; k++)
      for (int op = 0; op < 16; op++) begin
        logic [15:0] kk;
        kk = {12'h5A3 ^ 12'(k * 37), 4'(k)};
        drive(4'(op), kk, ref_locked(4'(op), kk), "R3 permuted map");
      end
    drain();

    // R4 / R5: single-bit flips around the correct key
    for (int b = 0; b < 16; b++) begin
      logic [15:0] fk;
      fk = GOOD_KEY ^ (16'd1 << b);
      diff_seen = 0;
      for (int op = 0; op < 16; op++)
        drive(4'(op), fk, (b < 4) ? ref_locked(4'(op), fk) : ref_map(4'(op)),
              (b < 4) ? "R4 flipped used bit" : "R5 upper bit ignored");
      drain();
      if (b < 4)
        check_cond(diff_seen > 0, "R4 mismatch exists for flip", diff_seen, 1);
      else
        check_cond(diff_seen == 0, "R5 no mismatch for upper flip", diff_seen, 0);
    end

    // R6: output follows an input change without a clock edge
    @(negedge clk);
    key = GOOD_KEY; opcode = 4'd2;
    #1;
    check_cond(alu_op === 4'd1, "R6 comb response add", int'(alu_op), 1);
    opcode = 4'd13;
    #1;
    check_cond(alu_op === 4'd12, "R6 comb response invert", int'(alu_op), 12);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(CLK_PERIOD * 5000);
    join_any
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule